// File: doc/BRIEF.md
# Two-Level Interrupt Acknowledge Sequencer

This block joins two eight-line interrupt controllers, a master and a slave, to a processor. It keeps the pending-request and in-service state of both levels. It captures the request lines in edge or level mode and resolves the winning line of each level under a rotating priority. Each level also honours its mask and any line already in service. The slave's combined request reaches master line 2. The master's result drives one interrupt output to the processor.

When the processor pulses the acknowledge input, the block runs the whole acknowledge in that clock. It marks the winner in service, drops its request if it was edge-captured, and descends into the slave when the master winner is line 2. It then registers an 8-bit vector made from the relevant vector base and line. If a level has nothing to give, line 7 stands in for it. Vector bases and mode bits are plain inputs, and software programming of these values is handled elsewhere.

Top module: `casack_seq`

## Requirements
- R1: A synchronous active-low reset clears every request, in-service and previous-input bit of both levels and sets both rotation bases to 0. After reset `cpu_int_o` and `vec_vld_o` are 0.
- R2: A request line whose mode bit is 0 is edge mode: its request bit is set by a 0-to-1 change of the input and stays set until acknowledged. A line whose mode bit is 1 is level mode: its request bit follows the input one clock later.
- R3: Within a level, the position of line i is (i - base) mod 8, and a lower position is more urgent. A line whose mask bit is 1 is not a candidate. The level has a winner when its most urgent unmasked request has a strictly lower position than its most urgent in-service bit. `cpu_int_o` is 1 exactly while the master has a winner.
- R4: In every clock in which the slave has a winner, master request bit 2 is set as an edge capture. The external master input bit 2 and master mode bit 2 have no effect.
- R5: On acknowledge with a master winner w other than 2, master in-service bit w is set and the vector is {master base[7:3], w}. Request bit w is cleared in edge mode and left pending in level mode. `ack_line_o` is w.
- R6: When the master winner is 2, the master is acknowledged as in R5 and the slave winner s is acknowledged the same way. The vector is {slave base[7:3], s} and `ack_line_o` is s + 8.
- R7: When the master winner is 2 and the slave has no winner, the vector is {slave base[7:3], 7} and `ack_line_o` is 15. The slave state is unchanged.
- R8: When the master has no winner at acknowledge, the vector is {master base[7:3], 7}, `ack_line_o` is 7, and neither level's in-service bits nor rotation base change.
- R9: With a level's auto end-of-interrupt bit set, an acknowledged line is not left in service. If that level's rotate bit is also set, its base becomes (acknowledged line + 1) mod 8.
- R10: `vec_vld_o` is 1 in exactly the clock after each clock in which `inta_i` is 1, and `vec_o` and `ack_line_o` are valid then.
- R11: The low three bits of each vector base input are ignored, so the low three bits of `vec_o` always equal `ack_line_o[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_req_i | input | 8 | Master request lines (bit 2 unused) |
| slv_req_i | input | 8 | Slave request lines |
| mst_mask_i | input | 8 | Master mask, 1 = line blocked |
| slv_mask_i | input | 8 | Slave mask, 1 = line blocked |
| mst_lvl_i | input | 8 | Master mode per line, 1 = level, 0 = edge |
| slv_lvl_i | input | 8 | Slave mode per line, 1 = level, 0 = edge |
| mst_base_i | input | 8 | Master vector base, bits 7:3 used |
| slv_base_i | input | 8 | Slave vector base, bits 7:3 used |
| mst_aeoi_i | input | 1 | Master auto end-of-interrupt |
| slv_aeoi_i | input | 1 | Slave auto end-of-interrupt |
| mst_rot_i | input | 1 | Master rotate on auto end-of-interrupt |
| slv_rot_i | input | 1 | Slave rotate on auto end-of-interrupt |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| cpu_int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Acknowledged vector |
| vec_vld_o | output | 1 | Vector valid, the clock after acknowledge |
| ack_line_o | output | 4 | Acknowledged line, 0-15, 7 or 15 when spurious |

## Verification
The embedded assertions watch every cycle for the following. Valid follows the acknowledge by one clock. The vector's low bits match the reported line. A non-spurious acknowledge leaves the winner in service unless auto end-of-interrupt is on. Level requests stay pending through their acknowledge. The cascade capture lands in master bit 2. A spurious master acknowledge freezes the in-service bits and the rotation base. Only the bench scenarios compared against the behavioural model can show the rest: nesting blocks lower lines and admits higher ones, the rotated priority order after a rotating acknowledge, the slave-level spurious vector, and the masking and ignored-input cases seen at `cpu_int_o`.

// File: rtl/casack_pkg.sv
// Shared sizing and types for the two-level acknowledge sequencer.
// Assumes the line count is a power of two so line arithmetic wraps.
package casack_pkg;
    localparam int unsigned LINES  = 8;
    localparam int unsigned LINE_W = $clog2(LINES);
    localparam int unsigned VEC_W  = 8;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [LINES-1:0]  lines_t;
endpackage

// File: rtl/casack_resolve.sv
// Priority resolver for one level: finds the most urgent unmasked request
// under a rotating base and compares it against the most urgent in-service
// line. Purely combinational. Assumes N is a power of two.
module casack_resolve #(
    parameter int unsigned N = casack_pkg::LINES,
    localparam int unsigned W = $clog2(N),
    localparam int unsigned RW = W + 1
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] serv_i,
    input  logic [N-1:0] mask_i,
    input  logic [W-1:0] base_i,
    output logic         win_vld_o,
    output logic [W-1:0] win_line_o
);
    // Position of the first set bit counted from the rotation base, N if none.
    function automatic logic [RW-1:0] first_rank(input logic [N-1:0] bits,
                                                  input logic [W-1:0] rot);
        logic [RW-1:0] r;
        r = RW'(N);
        for (int p = N - 1; p >= 0; p--) begin
            if (bits[W'(p) + rot]) r = RW'(p);
        end
        return r;
    endfunction

    logic [RW-1:0] req_rank;
    logic [RW-1:0] srv_rank;

    // Rank candidates and in-service lines, then decide the winner.
    always_comb begin
        req_rank   = first_rank(pend_i & ~mask_i, base_i);
        srv_rank   = first_rank(serv_i, base_i);
        win_vld_o  = (req_rank < srv_rank);
        win_line_o = req_rank[W-1:0] + base_i;
    end
endmodule

// File: rtl/casack_level.sv
// State of one controller level: request capture (edge or level per line),
// in-service bits, rotation base and the acknowledge update.
// Assumes ack_i is only asserted by the parent when this level is acknowledged;
// set_i forces edge-style request captures (used for the cascade line).
module casack_level #(
    parameter int unsigned N = casack_pkg::LINES,
    localparam int unsigned W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] lvl_i,
    input  logic         ack_i,
    input  logic         aeoi_i,
    input  logic         rot_i,
    output logic         win_vld_o,
    output logic [W-1:0] win_line_o
);
    logic [N-1:0] pend_q, pend_d;
    logic [N-1:0] serv_q, serv_d;
    logic [N-1:0] prev_q;
    logic [W-1:0] base_q, base_d;
    logic         take;
    logic [N-1:0] take_bit;
    logic [N-1:0] rise;

    casack_resolve #(.N(N)) u_resolve (
        .pend_i     (pend_q),
        .serv_i     (serv_q),
        .mask_i     (mask_i),
        .base_i     (base_q),
        .win_vld_o  (win_vld_o),
        .win_line_o (win_line_o)
    );

    // Next-state for requests, in-service bits and rotation base.
    always_comb begin
        take     = ack_i & win_vld_o;
        take_bit = take ? (N'(1) << win_line_o) : '0;
        rise     = req_i & ~prev_q;
        for (int i = 0; i < N; i++) begin
            if (lvl_i[i]) pend_d[i] = req_i[i];
            else          pend_d[i] = (pend_q[i] & ~take_bit[i]) | rise[i] | set_i[i];
        end
        serv_d = aeoi_i ? serv_q : (serv_q | take_bit);
        base_d = (take && aeoi_i && rot_i) ? (win_line_o + W'(1)) : base_q;
    end

    // Level state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            serv_q <= '0;
            prev_q <= '0;
            base_q <= '0;
        end else begin
            pend_q <= pend_d;
            serv_q <= serv_d;
            prev_q <= req_i;
            base_q <= base_d;
        end
    end

    a_r5_winner_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && win_vld_o && !aeoi_i) |=> serv_q[$past(win_line_o)]);

    a_r5_level_stays_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && win_vld_o && lvl_i[win_line_o] && req_i[win_line_o])
        |=> pend_q[$past(win_line_o)]);

    a_r9_rotate_base: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && win_vld_o && aeoi_i && rot_i) |=> (base_q == $past(win_line_o) + W'(1)));

    a_r8_spurious_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !win_vld_o) |=> ($stable(serv_q) && $stable(base_q)));

    a_r4_forced_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_q & $past(set_i & ~lvl_i)) == $past(set_i & ~lvl_i)));
endmodule

// File: rtl/casack_seq.sv
// Two-level acknowledge sequencer: a master and a slave level, the slave's
// winner feeding master line CAS_LINE, and the one-clock acknowledge that
// picks the vector. Assumes inta_i is a single-clock pulse per acknowledge.
module casack_seq #(
    parameter int unsigned N        = casack_pkg::LINES,
    parameter int unsigned VW       = casack_pkg::VEC_W,
    parameter int unsigned CAS_LINE = 2,
    localparam int unsigned W       = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  mst_req_i,
    input  logic [N-1:0]  slv_req_i,
    input  logic [N-1:0]  mst_mask_i,
    input  logic [N-1:0]  slv_mask_i,
    input  logic [N-1:0]  mst_lvl_i,
    input  logic [N-1:0]  slv_lvl_i,
    input  logic [VW-1:0] mst_base_i,
    input  logic [VW-1:0] slv_base_i,
    input  logic          mst_aeoi_i,
    input  logic          slv_aeoi_i,
    input  logic          mst_rot_i,
    input  logic          slv_rot_i,
    input  logic          inta_i,
    output logic          cpu_int_o,
    output logic [VW-1:0] vec_o,
    output logic          vec_vld_o,
    output logic [W:0]    ack_line_o
);
    localparam logic [N-1:0] CAS_BIT  = N'(1) << CAS_LINE;
    localparam logic [W-1:0] SPUR     = W'(N - 1);

    logic         m_vld, s_vld;
    logic [W-1:0] m_line, s_line;
    logic         m_is_cas;
    logic         s_ack;
    logic [VW-1:0] vec_d;
    logic [W:0]    line_d;
    logic [VW-1:0] vec_q;
    logic [W:0]    line_q;
    logic          vld_q;
    logic          unused_base_bits;

    assign unused_base_bits = ^{mst_base_i[W-1:0], slv_base_i[W-1:0]};

    assign m_is_cas = (m_line == W'(CAS_LINE));
    assign s_ack    = inta_i & m_vld & m_is_cas;

    casack_level #(.N(N)) u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (slv_req_i),
        .set_i      ('0),
        .mask_i     (slv_mask_i),
        .lvl_i      (slv_lvl_i),
        .ack_i      (s_ack),
        .aeoi_i     (slv_aeoi_i),
        .rot_i      (slv_rot_i),
        .win_vld_o  (s_vld),
        .win_line_o (s_line)
    );

    casack_level #(.N(N)) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (mst_req_i & ~CAS_BIT),
        .set_i      (s_vld ? CAS_BIT : '0),
        .mask_i     (mst_mask_i),
        .lvl_i      (mst_lvl_i & ~CAS_BIT),
        .ack_i      (inta_i),
        .aeoi_i     (mst_aeoi_i),
        .rot_i      (mst_rot_i),
        .win_vld_o  (m_vld),
        .win_line_o (m_line)
    );

    assign cpu_int_o = m_vld;

    // Choose vector and reported line for the acknowledge in progress.
    always_comb begin
        if (!m_vld) begin
            vec_d  = {mst_base_i[VW-1:W], SPUR};
            line_d = {1'b0, SPUR};
        end else if (!m_is_cas) begin
            vec_d  = {mst_base_i[VW-1:W], m_line};
            line_d = {1'b0, m_line};
        end else if (s_vld) begin
            vec_d  = {slv_base_i[VW-1:W], s_line};
            line_d = {1'b1, s_line};
        end else begin
            vec_d  = {slv_base_i[VW-1:W], SPUR};
            line_d = {1'b1, SPUR};
        end
    end

    // Register the vector for the clock after the acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            line_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= inta_i;
            if (inta_i) begin
                vec_q  <= vec_d;
                line_q <= line_d;
            end
        end
    end

    assign vec_o      = vec_q;
    assign ack_line_o = line_q;
    assign vec_vld_o  = vld_q;

    a_r10_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        inta_i |=> vec_vld_o);

    a_r10_no_valid_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_i |=> !vec_vld_o);

    a_r11_low_bits_match: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> (vec_o[W-1:0] == ack_line_o[W-1:0]));
endmodule

// File: tb/tb_casack_seq.sv
module tb_casack_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mst_req = '0, slv_req = '0, mst_mask = '0, slv_mask = '0;
    logic [7:0] mst_lvl = '0, slv_lvl = '0, mst_base = 8'h20, slv_base = 8'h70;
    logic       mst_aeoi = 0, slv_aeoi = 0, mst_rot = 0, slv_rot = 0, inta = 0;
    logic       cpu_int, vec_vld;
    logic [7:0] vec;
    logic [3:0] ack_line;

    int checks = 0, errors = 0;
    bit done = 0;

    // Behavioural reference state: index 0 master, 1 slave.
    int irr[2], isr[2], last[2], add[2];
    int e_vld = 0, e_vec = 0, e_line = 0;

    always #2.5 clk = ~clk;

    casack_seq dut (
        .clk(clk), .rst_n(rst_n), .mst_req_i(mst_req), .slv_req_i(slv_req),
        .mst_mask_i(mst_mask), .slv_mask_i(slv_mask), .mst_lvl_i(mst_lvl),
        .slv_lvl_i(slv_lvl), .mst_base_i(mst_base), .slv_base_i(slv_base),
        .mst_aeoi_i(mst_aeoi), .slv_aeoi_i(slv_aeoi), .mst_rot_i(mst_rot),
        .slv_rot_i(slv_rot), .inta_i(inta), .cpu_int_o(cpu_int), .vec_o(vec),
        .vec_vld_o(vec_vld), .ack_line_o(ack_line)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit pick(int l, int msk, output int line);
        int rq = 8, sv = 8;
        for (int p = 7; p >= 0; p--) begin
            int b = (p + add[l]) % 8;
            if (((irr[l] & ~msk) >> b) & 1) rq = p;
            if ((isr[l] >> b) & 1) sv = p;
        end
        line = (rq + add[l]) % 8;
        return rq < sv;
    endfunction

    task automatic model_step();
        int mw, sw, rq[2], lv[2], ae[2], ro[2], take[2], who[2];
        bit mv, sv;
        if (!rst_n) begin
            for (int l = 0; l < 2; l++) begin irr[l] = 0; isr[l] = 0; last[l] = 0; add[l] = 0; end
            e_vld = 0; e_vec = 0; e_line = 0;
            return;
        end
        mv = pick(0, int'(mst_mask), mw);
        sv = pick(1, int'(slv_mask), sw);
        rq[0] = int'(mst_req) & ~4; lv[0] = int'(mst_lvl) & ~4;
        rq[1] = int'(slv_req);      lv[1] = int'(slv_lvl);
        ae[0] = mst_aeoi; ae[1] = slv_aeoi; ro[0] = mst_rot; ro[1] = slv_rot;
        take[0] = inta && mv; who[0] = mw;
        take[1] = take[0] && mw == 2 && sv; who[1] = sw;
        e_vld = inta;
        if (inta) begin
            if (!mv) begin e_vec = (mst_base & 8'hF8) + 7; e_line = 7; end
            else if (mw != 2) begin e_vec = (mst_base & 8'hF8) + mw; e_line = mw; end
            else if (sv) begin e_vec = (slv_base & 8'hF8) + sw; e_line = sw + 8; end
            else begin e_vec = (slv_base & 8'hF8) + 7; e_line = 15; end
        end
        for (int l = 0; l < 2; l++) begin
            int nirr = 0;
            for (int b = 0; b < 8; b++) begin
                bit r = (rq[l] >> b) & 1;
                bit nb;
                if ((lv[l] >> b) & 1) nb = r;
                else nb = (((irr[l] >> b) & 1) && !(take[l] && who[l] == b))
                          || (r && !((last[l] >> b) & 1))
                          || (l == 0 && b == 2 && sv);
                if (nb) nirr |= (1 << b);
            end
            irr[l] = nirr;
            if (take[l] && !ae[l]) isr[l] |= (1 << who[l]);
            if (take[l] && ae[l] && ro[l]) add[l] = (who[l] + 1) % 8;
            last[l] = rq[l];
        end
    endtask

    task automatic compare();
        int mw;
        bit mv;
        mv = pick(0, int'(mst_mask), mw);
        check("R3 cpu_int vs model", int'(cpu_int), int'(mv));
        check("R10 vec_vld vs model", int'(vec_vld), e_vld);
        if (e_vld) begin
            string t;
            t = (e_line == 15) ? "R7" : (e_line >= 8) ? "R6" : "R5/R8";
            check({t, " vector vs model"}, int'(vec), e_vec);
            check({t, " line vs model"}, int'(ack_line), e_line);
        end
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        mst_req = '0; slv_req = '0; mst_mask = '0; slv_mask = '0; mst_lvl = '0; slv_lvl = '0;
        mst_aeoi = 0; slv_aeoi = 0; mst_rot = 0; slv_rot = 0; inta = 0;
        rst_n = 0; cyc(); cyc(); rst_n = 1;
    endtask

    task automatic ack();
        inta = 1; cyc(); inta = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 cpu_int after reset", int'(cpu_int), 0);
        check("R1 vec_vld after reset", int'(vec_vld), 0);

        // R8: masked pending request, spurious ack, state kept.
        mst_base = 8'h23; mst_req = 8'h01; mst_mask = 8'h01; cyc(); cyc();
        check("R3 masked line gives no interrupt", int'(cpu_int), 0);
        ack();
        check("R8 spurious master vector", int'(vec), 8'h27);
        check("R8 spurious master line", int'(ack_line), 7);
        mst_mask = 8'h00; cyc();
        check("R8 request still pending after spurious", int'(cpu_int), 1);
        ack();
        check("R11 base low bits ignored", int'(vec), 8'h20);

        // R2/R3/R5: edge capture, nesting.
        do_reset(); mst_base = 8'h20;
        mst_req = 8'h08; cyc();
        check("R2 edge request seen", int'(cpu_int), 1);
        mst_req = 8'h00; ack();
        check("R5 master vector line 3", int'(vec), 8'h23);
        cyc();
        check("R10 valid drops after pulse", int'(vec_vld), 0);
        check("R5 edge request cleared", int'(cpu_int), 0);
        mst_req = 8'h20; cyc(); cyc();
        check("R3 lower line blocked by in-service", int'(cpu_int), 0);
        mst_req = 8'h22; cyc();
        check("R3 higher line nests", int'(cpu_int), 1);

        // R5/R9: level mode with auto end-of-interrupt.
        do_reset(); mst_lvl = 8'h10; mst_aeoi = 1; mst_req = 8'h10; cyc();
        ack();
        check("R5 level line vector", int'(vec), 8'h24);
        cyc();
        check("R9 level request stays, not in service", int'(cpu_int), 1);
        ack();
        check("R9 repeat acknowledge", int'(vec), 8'h24);

        // R4: external master bit 2 ignored.
        do_reset(); mst_req = 8'h04; mst_lvl = 8'h04; cyc(); cyc(); cyc();
        check("R4 external bit 2 ignored", int'(cpu_int), 0);

        // R4/R6: cascaded acknowledge.
        do_reset(); slv_base = 8'h75; slv_req = 8'h40; cyc();
        check("R4 one clock: master not yet set", int'(cpu_int), 0);
        cyc();
        check("R4 slave forwarded to master", int'(cpu_int), 1);
        ack();
        check("R6 slave vector", int'(vec), 8'h76);
        check("R6 slave line", int'(ack_line), 14);

        // R7: slave loses its request after master captured it.
        do_reset(); slv_req = 8'h02; cyc(); cyc();
        slv_mask = 8'h02; ack();
        check("R7 spurious slave vector", int'(vec), 8'h77);
        check("R7 spurious slave line", int'(ack_line), 15);

        // R9: rotation changes priority order.
        do_reset(); mst_aeoi = 1; mst_rot = 1; mst_req = 8'h08; cyc();
        mst_req = 8'h00; ack();
        check("R9 first rotating ack", int'(vec), 8'h23);
        mst_req = 8'h22; cyc(); ack();
        check("R9 rotated base picks line 5", int'(vec), 8'h25);

        // R1: rotation base back to 0 after reset.
        do_reset(); mst_req = 8'h22; cyc(); ack();
        check("R1 base reset to 0", int'(vec), 8'h21);

        cyc();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule